// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status flags of an asynchronous serial port. Two kinds of event change the flags. The transmitter and receiver datapaths send one-cycle event pulses: transmit buffer moved into the shifter, last bit sent, and frame received with its data, parity bit, stop bit and multiprocessor bit. The CPU side sends register reads and writes, plus strobes that mark accesses to the transmit and receive data registers.

Software clears an error or buffer flag with a handshake. It first reads the register and sees the flag at 1, then writes 0 to that bit. Writing 1 to a flag never sets it. The block also decides whether a finished frame may be loaded into the receive data register. It raises a one-cycle load strobe for a frame without errors and holds that strobe back when the previous frame has not yet been taken.

Every flag updates on the clock edge that follows its event. The read data port returns the flag vector one cycle after a read strobe.

Top module: `uart_flag_reg`

## Requirements
- R1: The flag vector has tx-empty in bit 7, rx-full in bit 6, overrun in bit 5, framing error in bit 4, parity error in bit 3, tx-end in bit 2, received multiprocessor bit in bit 1 and transmit multiprocessor bit in bit 0. Synchronous reset makes it 8'h84.
- R2: `reg_rd` captures the flag vector into `rd_data` on the next edge. `rd_data` then holds that value until the next read.
- R3: A write of 0 to bit 7, 6, 5, 4 or 3 clears that flag only if a read since the last write returned it as 1. A write consumes that arming. Writing 1 to these bits has no effect. Writes never change bit 2 or bit 1.
- R4: Every write loads `wr_data[0]` into bit 0, which also drives `mpbt`.
- R5: Tx-empty is set by `tx_load` and on any cycle with `tx_en` low. It is cleared by `tdr_wr` or by the R3 handshake.
- R6: Tx-end is set by `tx_last_bit` while tx-empty is 1. It is cleared by the tx-empty handshake, by `tdr_wr`, or by `tx_en` low.
- R7: A frame that ends (`rx_done`) with a stop bit of 1 and no parity error, while rx-full is 0, pulses `rdr_load` in the same cycle. On the next edge it sets rx-full and copies `rx_mpb` into bit 1. Rx-full is cleared by `rdr_rd` or by the handshake.
- R8: A frame that ends while rx-full is 1 sets overrun, gives no `rdr_load` pulse, and leaves rx-full and bit 1 unchanged.
- R9: A stop bit of 0 sets the framing error. With `par_en` high, the parity error is set when the number of ones in `rx_data` plus `rx_parity_bit` is even and `par_odd` is 1, or odd and `par_odd` is 0. Either error blocks the load.
- R10: If a flag's set condition and a clear occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| wr_data | input | 8 | Write data |
| tdr_wr | input | 1 | CPU wrote the transmit data register |
| rdr_rd | input | 1 | CPU read the receive data register |
| tx_en | input | 1 | Transmitter enable |
| tx_load | input | 1 | Transmit data moved into the shifter |
| tx_last_bit | input | 1 | Last bit of a character has been sent |
| rx_done | input | 1 | Received frame complete |
| rx_data | input | DATA_W | Received data bits |
| rx_parity_bit | input | 1 | Received parity bit |
| rx_stop_bit | input | 1 | Sampled stop bit |
| rx_mpb | input | 1 | Received multiprocessor bit |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| status | output | 8 | Live flag vector |
| rd_data | output | 8 | Flag vector captured by the last read |
| rdr_load | output | 1 | Move the received frame into the receive data register |
| mpbt | output | 1 | Multiprocessor bit for transmitted frames |

## Verification
Flags and `rd_data` change on the edge after the strobe that causes them, so the bench compares them 1 ns after each rising edge. By then the edge has taken effect and no new stimulus has arrived. `rdr_load` depends in the same cycle on the present `rx_done` and rx-full, so it is compared at that same point against the model's decision for the current inputs. The behavioural model advances at every edge from the inputs held since the previous falling edge, so every expected value refers to exactly one register stage.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int FLAG_W = 8;
  localparam int B_TXE  = 7;
  localparam int B_RXF  = 6;
  localparam int B_OVR  = 5;
  localparam int B_FRM  = 4;
  localparam int B_PAR  = 3;
  localparam int B_TXD  = 2;
  localparam int B_MPR  = 1;
  localparam int B_MPT  = 0;
  localparam logic [FLAG_W-1:0] RESET_FLAGS = 8'h84;
  // bits that software may clear by the read-1 / write-0 handshake
  localparam logic [FLAG_W-1:0] SW_CLR_MASK = 8'hF8;
endpackage

// File: rtl/ufr_rx_eval.sv
module ufr_rx_eval #(
  parameter int DATA_W = 8
) (
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_parity_bit,
  input  logic              rx_stop_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxf_now,
  output logic              frame_err,
  output logic              parity_err,
  output logic              overrun,
  output logic              load
);
  logic ones_odd;

  always_comb begin
    ones_odd   = (^rx_data) ^ rx_parity_bit;
    frame_err  = rx_done && !rx_stop_bit;
    parity_err = rx_done && par_en && (ones_odd != par_odd);
    overrun    = rx_done && rxf_now;
    load       = rx_done && !rxf_now && rx_stop_bit && !(par_en && (ones_odd != par_odd));
  end
endmodule

// File: rtl/ufr_clear_arm.sv
module ufr_clear_arm #(
  parameter int                W    = 8,
  parameter logic [W-1:0]      MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] flags,
  output logic [W-1:0] clr
);
  logic [W-1:0] raw;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic armed_q;
    always_ff @(posedge clk) begin
      if (rst)      armed_q <= 1'b0;
      else if (rd)  armed_q <= flags[i];
      else if (wr)  armed_q <= 1'b0;
      else          armed_q <= armed_q & flags[i];
    end
    assign raw[i] = wr && !wr_data[i] && armed_q;
  end

  assign clr = raw & MASK;
endmodule

// File: rtl/uart_flag_reg.sv
module uart_flag_reg
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        wr_data,
  input  logic              tdr_wr,
  input  logic              rdr_rd,
  input  logic              tx_en,
  input  logic              tx_load,
  input  logic              tx_last_bit,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_parity_bit,
  input  logic              rx_stop_bit,
  input  logic              rx_mpb,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [7:0]        status,
  output logic [7:0]        rd_data,
  output logic              rdr_load,
  output logic              mpbt
);
  logic [FLAG_W-1:0] flags_q, flags_d, rd_q, clr;
  logic frame_err, parity_err, overrun, load;

  ufr_clear_arm #(.W(FLAG_W), .MASK(SW_CLR_MASK)) i_arm (
    .clk(clk), .rst(rst), .rd(reg_rd), .wr(reg_wr),
    .wr_data(wr_data), .flags(flags_q), .clr(clr)
  );

  ufr_rx_eval #(.DATA_W(DATA_W)) i_rx (
    .rx_done(rx_done), .rx_data(rx_data), .rx_parity_bit(rx_parity_bit),
    .rx_stop_bit(rx_stop_bit), .par_en(par_en), .par_odd(par_odd),
    .rxf_now(flags_q[B_RXF]), .frame_err(frame_err), .parity_err(parity_err),
    .overrun(overrun), .load(load)
  );

  // set conditions are tested first so they win over any clear
  always_comb begin
    flags_d = flags_q;
    if (!tx_en || tx_load)                        flags_d[B_TXE] = 1'b1;
    else if (clr[B_TXE] || tdr_wr)                flags_d[B_TXE] = 1'b0;

    if (tx_last_bit && flags_q[B_TXE])            flags_d[B_TXD] = 1'b1;
    else if (clr[B_TXE] || tdr_wr || !tx_en)      flags_d[B_TXD] = 1'b0;

    if (load)                                     flags_d[B_RXF] = 1'b1;
    else if (clr[B_RXF] || rdr_rd)                flags_d[B_RXF] = 1'b0;

    if (overrun)                                  flags_d[B_OVR] = 1'b1;
    else if (clr[B_OVR])                          flags_d[B_OVR] = 1'b0;

    if (frame_err)                                flags_d[B_FRM] = 1'b1;
    else if (clr[B_FRM])                          flags_d[B_FRM] = 1'b0;

    if (parity_err)                               flags_d[B_PAR] = 1'b1;
    else if (clr[B_PAR])                          flags_d[B_PAR] = 1'b0;

    if (load)                                     flags_d[B_MPR] = rx_mpb;
    if (reg_wr)                                   flags_d[B_MPT] = wr_data[B_MPT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= RESET_FLAGS;
      rd_q    <= '0;
    end else begin
      flags_q <= flags_d;
      if (reg_rd) rd_q <= flags_q;
    end
  end

  assign status   = flags_q;
  assign rd_data  = rd_q;
  assign rdr_load = load;
  assign mpbt     = flags_q[B_MPT];
endmodule

// File: rtl/uart_flag_reg_chk.sv
module uart_flag_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [7:0] wr_data,
  input logic       tx_en,
  input logic       tx_last_bit,
  input logic       rx_done,
  input logic [7:0] status,
  input logic       rdr_load
);
  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> status == 8'h84); // R1
  AST_WR_MPBT: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> status[0] == $past(wr_data[0])); // R4
  AST_TXE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> status[7]); // R5
  AST_TEND_SET: assert property (@(posedge clk) disable iff (rst)
    tx_last_bit && status[7] |=> status[2]); // R6
  AST_OVR_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    rx_done && status[6] |-> !rdr_load); // R8
  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (rst)
    rx_done && status[6] |=> status[5]); // R8
  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (rst)
    status[4] && !reg_wr |=> status[4]); // R3
endmodule

bind uart_flag_reg uart_flag_reg_chk i_chk (.*);

// File: tb/test_uart_flag_reg.sv
module test_uart_flag_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_rd = 0, reg_wr = 0, tdr_wr = 0, rdr_rd = 0, tx_en = 0;
  logic tx_load = 0, tx_last_bit = 0, rx_done = 0, rx_parity_bit = 0;
  logic rx_stop_bit = 1, rx_mpb = 0, par_en = 0, par_odd = 0;
  logic [7:0] wr_data = 0, rx_data = 0;
  logic [7:0] status, rd_data;
  logic rdr_load, mpbt;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;
  logic [7:0] m_f, m_arm, m_rd;

  always #2 clk = ~clk;

  uart_flag_reg i_uart_flag_reg (.*);

  function automatic string req_of(int b);
    case (b)
      7: return "R5"; 6: return "R7"; 5: return "R8"; 4: return "R9";
      3: return "R9"; 2: return "R6"; 1: return "R7"; default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit par_bad();
    int n = 0;
    for (int i = 0; i < 8; i++) n += rx_data[i];
    n += rx_parity_bit;
    return par_en && ((n % 2) != par_odd);
  endfunction

  function automatic bit m_good();
    return rx_done && rx_stop_bit && !par_bad() && !m_f[6];
  endfunction

  // behavioural reference, advanced at each edge
  always @(posedge clk) begin
    logic [7:0] o, n, sw;
    bit good;
    cyc++;
    if (rst) begin
      m_f = 8'h84; m_arm = 0; m_rd = 0; started = 1;
    end else begin
      o = m_f; n = o; good = m_good();
      for (int i = 3; i < 8; i++) sw[i] = reg_wr && !wr_data[i] && m_arm[i];
      sw[2:0] = 0;
      n[7] = (!tx_en || tx_load) ? 1'b1 : ((sw[7] || tdr_wr) ? 1'b0 : o[7]);
      n[2] = (tx_last_bit && o[7]) ? 1'b1 : ((sw[7] || tdr_wr || !tx_en) ? 1'b0 : o[2]);
      n[6] = good ? 1'b1 : ((sw[6] || rdr_rd) ? 1'b0 : o[6]);
      n[5] = (rx_done && o[6]) ? 1'b1 : (sw[5] ? 1'b0 : o[5]);
      n[4] = (rx_done && !rx_stop_bit) ? 1'b1 : (sw[4] ? 1'b0 : o[4]);
      n[3] = (rx_done && par_bad()) ? 1'b1 : (sw[3] ? 1'b0 : o[3]);
      if (good) n[1] = rx_mpb;
      if (reg_wr) n[0] = wr_data[0];
      if (reg_rd) begin m_arm = o; m_rd = o; end
      else if (reg_wr) m_arm = 0;
      else m_arm = m_arm & o;
      m_f = n;
    end
    #1;
    if (started) begin
      for (int b = 0; b < 8; b++) chk(req_of(b), 8'(status[b]), 8'(m_f[b]));
      chk("R2", rd_data, m_rd);
      chk("R4", 8'(mpbt), 8'(m_f[0]));
      if (!rst) chk("R7", 8'(rdr_load), 8'(m_good()));
    end
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic clear_pulses();
    reg_rd = 0; reg_wr = 0; tdr_wr = 0; rdr_rd = 0;
    tx_load = 0; tx_last_bit = 0; rx_done = 0;
  endtask

  task automatic frame(logic [7:0] d, logic p, logic stop, logic mpb);
    rx_data = d; rx_parity_bit = p; rx_stop_bit = stop; rx_mpb = mpb; rx_done = 1;
    tick(); clear_pulses();
  endtask

  initial begin
    repeat (3) tick();
    chk("R1", status, 8'h84);
    rst = 0; tx_en = 1;
    tick();
    // transmit path
    tdr_wr = 1; tick(); clear_pulses();
    chk("R5", 8'(status[7]), 8'd0);
    tx_load = 1; tick(); clear_pulses();
    tx_last_bit = 1; tick(); clear_pulses();
    chk("R6", 8'(status[2]), 8'd1);
    // write 0 without read: no clear
    reg_wr = 1; wr_data = 8'h00; tick(); clear_pulses();
    chk("R3", 8'(status[7]), 8'd1);
    // read then write 1s: nothing cleared, mpbt set
    reg_rd = 1; tick(); clear_pulses();
    reg_wr = 1; wr_data = 8'hFF; tick(); clear_pulses();
    chk("R3", status & 8'hFC, 8'h84);
    chk("R4", 8'(mpbt), 8'd1);
    // read then write 0: handshake clears tx-empty and tx-end
    reg_rd = 1; tick(); clear_pulses();
    reg_wr = 1; wr_data = 8'h00; tick(); clear_pulses();
    chk("R3", status & 8'h84, 8'h00);
    // receive path, even parity enabled
    par_en = 1; par_odd = 0;
    frame(8'h5A, 1'b0, 1'b1, 1'b1);
    chk("R7", status & 8'h7A, 8'h42);
    frame(8'h33, 1'b0, 1'b1, 1'b0);
    chk("R8", status & 8'h62, 8'h62);
    rdr_rd = 1; tick(); clear_pulses();
    chk("R7", 8'(status[6]), 8'd0);
    frame(8'h01, 1'b1, 1'b0, 1'b0);
    chk("R9", status & 8'h50, 8'h10);
    par_odd = 1;
    frame(8'h03, 1'b0, 1'b1, 1'b0);
    chk("R9", status & 8'h48, 8'h08);
    // set wins over same-cycle handshake clear of framing error
    reg_rd = 1; tick(); clear_pulses();
    reg_wr = 1; wr_data = 8'h00;
    frame(8'h00, 1'b1, 1'b0, 1'b0);
    chk("R10", 8'(status[4]), 8'd1);
    // transmitter disabled
    tx_en = 0; tick(); tick();
    chk("R5", status & 8'h84, 8'h80);
    tx_en = 1;
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom;
      reg_rd = (r % 6) == 0; reg_wr = ((r >> 3) % 7) == 0;
      wr_data = 8'($urandom); tdr_wr = ((r >> 6) % 9) == 0;
      rdr_rd = ((r >> 9) % 8) == 0; tx_en = ((r >> 12) % 40) != 0;
      tx_load = ((r >> 18) % 7) == 0; tx_last_bit = ((r >> 21) % 6) == 0;
      rx_done = ((r >> 24) % 5) == 0; rx_data = 8'($urandom);
      rx_parity_bit = r[27]; rx_stop_bit = ((r >> 28) % 8) != 0;
      rx_mpb = r[31]; par_en = r[30]; par_odd = r[29];
      tick();
    end
    clear_pulses();
    tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule